// File: doc/BRIEF.md
# Memory Protection Region Checker

This block is a small memory protection unit with eight programmable address regions. Software sets it up through a simple register port. Each region has a base address, a power-of-two size, an enable, an access-permission field and an execute-never flag. A separate lookup port takes an access address together with a flag for instruction fetches, a flag for privileged accesses and a flag for code running in a fault or non-maskable interrupt handler. In the same cycle the lookup port answers allow or deny and gives a fault-cause code.

When several enabled regions cover an address, the highest-numbered one decides. Software can therefore mark a large RAM window execute-never in a low region and then open small executable holes with higher regions. Each denied instruction fetch raises a one-cycle fault pulse and captures the fetch address into a readable register. Memory-type bits in the attribute field are stored and read back, but they have no effect on a lookup.

Top module: `mprot_unit`

## Requirements
- R1: Register index 0 is read-only and always reads 0x00000800. Bits [15:8] hold the region count of 8 and bit 0 is 0, which means one unified map for instructions and data. Writes to it have no effect.
- R2: Register index 1 is the control register and holds bits [2:0]. While bit 0 is clear, every lookup is allowed with cause 0.
- R3: Register index 2 selects a region (bits [2:0]). Index 3 (base, bits [31:5] kept, low bits read 0) and index 4 (size/attribute) write and read the fields of the selected region. Read data appears with rd_valid one cycle after rd_en.
- R4: In the index 4 word, bit 0 is the region enable and bits [5:1] hold N, giving a region of 2^(N+1) bytes. An address matches when it equals the base once the low N+1 bits of both are ignored.
- R5: A write to index 4 with N below 4 stores N but leaves the region disabled, so the enable bit reads back as 0.
- R6: A region whose enable is clear takes no part in any lookup.
- R7: When several enabled regions match, only the highest-numbered one applies.
- R8: Bit 28 of the index 4 word (attribute bit 12) is execute-never. A fetch that hits such a region is denied with cause 1. A data access to the same region is allowed when the permission is 3. The cause encoding is 0 for none, 1 for an instruction violation and 2 for a data violation.
- R9: Bits [26:24] of the index 4 word (attribute bits [10:8]) give the permission. A value of 0 denies every access, a value of 3 allows every access, and any other value allows privileged accesses only. A denial gives cause 1 for a fetch and cause 2 for a data access.
- R10: While the unit is active and no region matches, a privileged access is allowed only if control bit 2 is set. An unprivileged access is always denied.
- R11: While lk_handler is high and control bit 1 is clear, the unit behaves as disabled. With bit 1 set, it keeps checking.
- R12: A valid lookup with cause 1 raises flt_pulse in the next cycle and stores its address in register index 5. A data violation raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_idx | input | 3 | Register index for the read |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | 32 | Access address |
| lk_fetch | input | 1 | Access is an instruction fetch |
| lk_priv | input | 1 | Access is privileged |
| lk_handler | input | 1 | Access comes from a fault or NMI handler |
| lk_allow | output | 1 | Access allowed (combinational) |
| lk_cause | output | 2 | Fault cause: 0 none, 1 instruction, 2 data |
| flt_pulse | output | 1 | One-cycle pulse after an instruction violation |

## Verification
The allow/deny answer and the cause code follow the lookup inputs in the same cycle. The bench drives the lookup inputs on a falling edge and samples the answer shortly afterwards, before the next rising edge. Register writes take effect at the rising edge that ends the write cycle, and read data and flt_pulse are due one rising edge after their stimulus. The bench therefore checks both at the following falling edge: read results through a queue of expected values, and the pulse inside the lookup task.

// File: rtl/mprot_pkg.sv
package mprot_pkg;
  localparam int ADDR_W = 32;
  localparam int MIN_N  = 4;

  typedef enum logic [2:0] {
    RG_TYPE  = 3'd0,
    RG_CTRL  = 3'd1,
    RG_SEL   = 3'd2,
    RG_BASE  = 3'd3,
    RG_SZAT  = 3'd4,
    RG_FADDR = 3'd5
  } reg_idx_e;

  localparam logic [1:0] CZ_NONE  = 2'd0;
  localparam logic [1:0] CZ_INSTR = 2'd1;
  localparam logic [1:0] CZ_DATA  = 2'd2;

  typedef struct packed {
    logic [ADDR_W-1:5] base_hi;
    logic [4:0]        n;
    logic              en;
    logic [15:0]       attr;
  } region_t;

  // Address bits above the region size take part in the compare.
  function automatic logic [ADDR_W-1:0] keep_mask(input logic [4:0] n);
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i > int'(n));
    return m;
  endfunction
endpackage

// File: rtl/mprot_regs.sv
module mprot_regs
  import mprot_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [2:0]                  wr_idx,
  input  logic [31:0]                 wr_data,
  input  logic                        rd_en,
  input  logic [2:0]                  rd_idx,
  input  logic                        flt_set,
  input  logic [ADDR_W-1:0]           flt_addr_in,
  output logic [31:0]                 rd_data,
  output logic                        rd_valid,
  output logic [2:0]                  ctrl,
  output region_t [NUM_REGIONS-1:0]   regions
);
  localparam int SEL_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam logic [31:0] TYPE_VAL = 32'(NUM_REGIONS) << 8;

  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] faddr_q;
  logic              unused_wr;
  region_t           cur;

  assign unused_wr = ^wr_data[15:6];
  assign cur       = regions[sel_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      sel_q   <= '0;
      faddr_q <= '0;
      for (int i = 0; i < NUM_REGIONS; i++) regions[i] <= '0;
    end else begin
      if (wr_en) begin
        case (reg_idx_e'(wr_idx))
          RG_CTRL: ctrl  <= wr_data[2:0];
          RG_SEL:  sel_q <= wr_data[SEL_W-1:0];
          RG_BASE: regions[sel_q].base_hi <= wr_data[ADDR_W-1:5];
          RG_SZAT: begin
            regions[sel_q].n    <= wr_data[5:1];
            regions[sel_q].en   <= wr_data[0] && (wr_data[5:1] >= 5'(MIN_N));
            regions[sel_q].attr <= wr_data[31:16];
          end
          default: ;
        endcase
      end
      if (flt_set) faddr_q <= flt_addr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (reg_idx_e'(rd_idx))
          RG_TYPE:  rd_data <= TYPE_VAL;
          RG_CTRL:  rd_data <= {29'd0, ctrl};
          RG_SEL:   rd_data <= 32'(sel_q);
          RG_BASE:  rd_data <= {cur.base_hi, 5'd0};
          RG_SZAT:  rd_data <= {cur.attr, 10'd0, cur.n, cur.en};
          RG_FADDR: rd_data <= faddr_q;
          default:  rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/mprot_lookup.sv
module mprot_lookup
  import mprot_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  region_t [NUM_REGIONS-1:0] regions,
  input  logic [2:0]                ctrl,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      fetch,
  input  logic                      priv,
  input  logic                      handler,
  output logic                      allow,
  output logic [1:0]                cause
);
  logic [NUM_REGIONS-1:0] hit;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    logic [ADDR_W-1:0] m;
    assign m      = keep_mask(regions[g].n);
    assign hit[g] = regions[g].en &&
                    ((addr & m) == ({regions[g].base_hi, 5'd0} & m));
  end

  logic        found;
  logic [15:0] attr_sel;
  logic        active;
  logic        ok;
  logic        unused_attr;

  // Later (higher-numbered) hits override earlier ones.
  always_comb begin
    found    = 1'b0;
    attr_sel = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit[i]) begin
        found    = 1'b1;
        attr_sel = regions[i].attr;
      end
    end
  end

  assign unused_attr = ^{attr_sel[15:13], attr_sel[11], attr_sel[7:0]};
  assign active      = ctrl[0] && (!handler || ctrl[1]);

  always_comb begin
    if (!active) begin
      ok = 1'b1;
    end else if (!found) begin
      ok = priv && ctrl[2];
    end else begin
      case (attr_sel[10:8])
        3'd0:    ok = 1'b0;
        3'd3:    ok = 1'b1;
        default: ok = priv;
      endcase
      if (fetch && attr_sel[12]) ok = 1'b0;
    end
  end

  assign allow = ok;
  assign cause = ok ? CZ_NONE : (fetch ? CZ_INSTR : CZ_DATA);
endmodule

// File: rtl/mprot_unit.sv
module mprot_unit
  import mprot_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [2:0]  rd_idx,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  input  logic        lk_valid,
  input  logic [31:0] lk_addr,
  input  logic        lk_fetch,
  input  logic        lk_priv,
  input  logic        lk_handler,
  output logic        lk_allow,
  output logic [1:0]  lk_cause,
  output logic        flt_pulse
);
  region_t [NUM_REGIONS-1:0] regions;
  logic [2:0] ctrl_q;
  logic       flt_set;

  assign flt_set = lk_valid && (lk_cause == CZ_INSTR);

  mprot_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .flt_set(flt_set), .flt_addr_in(lk_addr),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .ctrl(ctrl_q), .regions(regions)
  );

  mprot_lookup #(.NUM_REGIONS(NUM_REGIONS)) u_lookup (
    .regions(regions), .ctrl(ctrl_q),
    .addr(lk_addr), .fetch(lk_fetch), .priv(lk_priv), .handler(lk_handler),
    .allow(lk_allow), .cause(lk_cause)
  );

  always_ff @(posedge clk) begin
    if (rst) flt_pulse <= 1'b0;
    else     flt_pulse <= flt_set;
  end
endmodule

// File: rtl/mprot_unit_chk.sv
module mprot_unit_chk #(
  parameter int NUM_REGIONS = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        rd_en,
  input logic [2:0]  rd_idx,
  input logic [31:0] rd_data,
  input logic        lk_valid,
  input logic        lk_fetch,
  input logic        lk_allow,
  input logic [1:0]  lk_cause,
  input logic        flt_pulse,
  input logic [2:0]  ctrl_q
);
  AST_TYPE_FIXED: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_idx == 3'd0) |=> (rd_data == (32'(NUM_REGIONS) << 8))); // R1
  AST_OFF_ALLOWS: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[0] |-> (lk_allow && lk_cause == 2'd0)); // R2
  AST_DENY_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !lk_allow |-> (lk_cause != 2'd0)); // R8
  AST_INSTR_CAUSE_FETCH: assert property (@(posedge clk) disable iff (rst)
    (lk_cause == 2'd1) |-> lk_fetch); // R9
  AST_DATA_CAUSE_NOFETCH: assert property (@(posedge clk) disable iff (rst)
    (lk_cause == 2'd2) |-> !lk_fetch); // R9
  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_cause == 2'd1) |=> flt_pulse); // R12
  AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    flt_pulse |-> $past(lk_valid && lk_cause == 2'd1)); // R12
endmodule

bind mprot_unit mprot_unit_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
  .lk_valid(lk_valid), .lk_fetch(lk_fetch), .lk_allow(lk_allow),
  .lk_cause(lk_cause), .flt_pulse(flt_pulse), .ctrl_q(ctrl_q)
);

// File: tb/sim_mprot_unit.sv
module sim_mprot_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  wr_idx = '0, rd_idx = '0;
  logic [31:0] wr_data = '0, rd_data, lk_addr = '0;
  logic        rd_valid, lk_valid = 1'b0, lk_fetch = 1'b0, lk_priv = 1'b0;
  logic        lk_handler = 1'b0, lk_allow, flt_pulse;
  logic [1:0]  lk_cause;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  mprot_unit u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read data as results appear.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("R3 unexpected read", rd_data, 32'hx);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, input logic [31:0] exp, input string req);
    @(negedge clk); rd_en = 1'b1; rd_idx = idx;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic f, input logic p, input logic h,
                      input logic exp_ok, input logic [1:0] exp_c, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_fetch = f; lk_priv = p; lk_handler = h;
    #1;
    check({req, " allow"}, 32'(lk_allow), 32'(exp_ok));
    check({req, " cause"}, 32'(lk_cause), 32'(exp_c));
    @(negedge clk);
    lk_valid = 1'b0;
    check({req, " R12 pulse"}, 32'(flt_pulse), 32'(exp_c == 2'd1));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(3'd0, 32'h0000_0800, "R1 type after reset");
    rd(3'd1, 32'h0, "R2 ctrl after reset");
    rd(3'd5, 32'h0, "R12 fault addr after reset");
    look(32'h2000_0010, 1, 0, 0, 1, 2'd0, "R2 disabled allows");
    wr(3'd0, 32'h1234_5678);
    rd(3'd0, 32'h0000_0800, "R1 write ignored");
    // Region 0: 32 KB RAM, execute-never, full access.
    wr(3'd2, 32'd0);
    wr(3'd3, 32'h2000_0000);
    wr(3'd4, 32'h1306_001D);
    rd(3'd3, 32'h2000_0000, "R3 base readback");
    rd(3'd4, 32'h1306_001D, "R3 size/attr readback");
    // Region 7: 32-byte executable hole.
    wr(3'd2, 32'd7);
    wr(3'd3, 32'h2000_5980);
    wr(3'd4, 32'h0306_0009);
    rd(3'd2, 32'd7, "R3 select readback");
    // Region 3: N=3 too small.
    wr(3'd2, 32'd3);
    wr(3'd3, 32'h4000_0000);
    wr(3'd4, 32'h0306_0007);
    rd(3'd4, 32'h0306_0006, "R5 small region not enabled");
    wr(3'd1, 32'h1);
    rd(3'd1, 32'h1, "R2 ctrl readback");
    look(32'h4000_0000, 0, 1, 0, 0, 2'd2, "R5 small region no match");
    look(32'h2000_0100, 1, 1, 0, 0, 2'd1, "R8 xn fetch denied");
    rd(3'd5, 32'h2000_0100, "R12 fault address captured");
    look(32'h2000_0100, 0, 0, 0, 1, 2'd0, "R8 data allowed in xn");
    look(32'h2000_5984, 1, 0, 0, 1, 2'd0, "R7 higher region hole");
    look(32'h2000_59A0, 1, 0, 0, 0, 2'd1, "R4 just past hole");
    // Region 5: base low bits ignored.
    wr(3'd2, 32'd5);
    wr(3'd3, 32'h1000_0013);
    rd(3'd3, 32'h1000_0000, "R3 base low bits dropped");
    wr(3'd4, 32'h0300_0009);
    look(32'h1000_001F, 1, 0, 0, 1, 2'd0, "R4 last byte of region");
    look(32'h1000_0020, 1, 0, 0, 0, 2'd1, "R4 outside region");
    wr(3'd4, 32'h0100_0009);
    look(32'h1000_0004, 0, 0, 0, 0, 2'd2, "R9 priv-only denies user");
    look(32'h1000_0004, 0, 1, 0, 1, 2'd0, "R9 priv-only allows priv");
    wr(3'd4, 32'h0000_0009);
    look(32'h1000_0004, 0, 1, 0, 0, 2'd2, "R9 no access");
    look(32'h1000_0004, 1, 1, 0, 0, 2'd1, "R9 no access fetch");
    wr(3'd4, 32'h0300_0008);
    look(32'h1000_0004, 0, 1, 0, 0, 2'd2, "R6 disabled region ignored");
    wr(3'd1, 32'h5);
    look(32'h1000_0004, 0, 1, 0, 1, 2'd0, "R10 default map priv");
    look(32'h1000_0004, 0, 0, 0, 0, 2'd2, "R10 default map user denied");
    look(32'h2000_0100, 1, 1, 1, 1, 2'd0, "R11 handler bypass");
    wr(3'd1, 32'h7);
    look(32'h2000_0100, 1, 1, 1, 0, 2'd1, "R11 handler checked");
    rd(3'd5, 32'h2000_0100, "R12 fault address handler");
    repeat (3) @(negedge clk);
    check("R3 read queue drained", 32'(exp_q.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule